// File: doc/BRIEF.md
# GSV Satellite Signal-Strength Extractor

This block sits behind a UART receiver that is wired to a GNSS monitoring receiver. It watches the incoming ASCII byte stream, picks out GPS satellites-in-view sentences, and splits each one into fields. From every satellite group in such a sentence it keeps the satellite number and the carrier-to-noise density. Each pair goes into a small register table. A host reads the table through a combinational read port, so it can show live signal quality.

Field separators are the comma, the asterisk and the carriage return, and all three behave the same way. Because of this, the checksum becomes an ordinary trailing field, and the last signal-strength field is closed without any special case. Every table slot is written as soon as its signal-strength field ends. An update pulse marks the line feed of the final message of a satellites-in-view group.

The parser is one state machine with four states. PARSE_IDLE waits for a `$`. PARSE_HEADER matches the five header letters and then a separator. PARSE_FIELDS collects fields. PARSE_SKIP discards bytes until the next `$`. The transitions are as follows:
- `$` from any state goes to PARSE_HEADER.
- A mismatched header letter moves PARSE_HEADER to PARSE_SKIP.
- A separator after the fifth letter moves PARSE_HEADER to PARSE_FIELDS.
- A message number that is out of range moves PARSE_FIELDS to PARSE_SKIP.
- A line feed moves PARSE_FIELDS to PARSE_IDLE.

Top module: `gsv_cn0_extractor`

## Requirements
- R1: After reset, every table slot reads satellite 0, signal 0 and not-tracked 1, and all three pulse outputs are low.
- R2: Only sentences whose header is exactly `$GPGSV` are parsed. Any other header (for example `$GPGSA` or `$GLGSV`) is skipped up to the next `$`, with no table write and no pulse.
- R3: The comma (0x2C), asterisk (0x2A) and carriage return (0x0D) each end the current field in the same way.
- R4: The fields after the header are, in order: total messages, message number, satellites in view, then up to four groups of (satellite, elevation, azimuth, signal). Group g of message m is stored in slot (m-1)*4+g. The satellite is saturated to 8 bits (255). The signal is saturated to 99 in 7 bits.
- R5: An empty signal field stores signal 0 and sets the slot's not-tracked bit. A non-empty field clears that bit.
- R6: A message number of 0, or above 8 (depth 32 divided by 4 groups), aborts the sentence. It gives a one-cycle `drop_pulse` and writes nothing.
- R7: A `$` received in the middle of a sentence abandons it and starts header matching again.
- R8: A numeric field longer than three digits keeps the value of its first three digits and gives a one-cycle `fmt_err`.
- R9: `upd_pulse` is high for exactly one cycle after a line feed (0x0A) ends a sentence whose message number equals its total. Otherwise it stays low.
- R10: A slot's new contents can be read on the cycle after the byte that ends its signal field is accepted, before the sentence ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | `rx_byte` holds a received character this cycle |
| rx_byte | input | 8 | Received ASCII character |
| rd_slot | input | 5 | Table slot to read |
| rd_sat | output | 8 | Satellite number in the addressed slot |
| rd_cn0 | output | 7 | Signal strength in dB-Hz in the addressed slot |
| rd_untracked | output | 1 | Addressed slot had an empty signal field |
| upd_pulse | output | 1 | Last message of a group finished |
| fmt_err | output | 1 | A field exceeded three digits |
| drop_pulse | output | 1 | Sentence dropped for an out-of-range message number |

## Verification
The assertions assume that `rx_byte` carries a defined value whenever `rx_valid` is high. They also assume that `rx_valid` is held low during reset, so the update and restart properties only ever look back at real accepted characters. The stimulus drives characters only on falling edges, keeps `rx_valid` low through reset and between sentences, and uses printable ASCII plus CR and LF. The bench checks the read port and counts pulses at falling edges, so each expected value is taken one register stage after the accepting rising edge.

// File: rtl/gsv_pkg.sv
package gsv_pkg;

    typedef enum logic [1:0] {
        PARSE_IDLE   = 2'd0,
        PARSE_HEADER = 2'd1,
        PARSE_FIELDS = 2'd2,
        PARSE_SKIP   = 2'd3
    } parse_state_t;

    localparam logic [7:0] CH_DOLLAR = 8'h24;
    localparam logic [7:0] CH_COMMA  = 8'h2C;
    localparam logic [7:0] CH_STAR   = 8'h2A;
    localparam logic [7:0] CH_CR     = 8'h0D;
    localparam logic [7:0] CH_LF     = 8'h0A;
    localparam int         HDR_LEN   = 5;
    localparam int         ACC_W     = 10;
    localparam int         ACC_MAX   = 999;

    function automatic logic [7:0] hdr_char(input logic [2:0] pos);
        case (pos)
            3'd0:    hdr_char = 8'h47;
            3'd1:    hdr_char = 8'h50;
            3'd2:    hdr_char = 8'h47;
            3'd3:    hdr_char = 8'h53;
            default: hdr_char = 8'h56;
        endcase
    endfunction

endpackage

// File: rtl/gsv_field_acc.sv
module gsv_field_acc
    import gsv_pkg::*;
#(
    parameter int MAX_DIGITS = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             dig_en,
    input  logic [3:0]       dig,
    output logic [ACC_W-1:0] value,
    output logic             empty,
    output logic             overflow
);
    localparam int ND_W = $clog2(MAX_DIGITS + 1);

    logic [ND_W-1:0] ndig;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            value <= '0;
            ndig  <= '0;
        end else if (dig_en && ndig < ND_W'(MAX_DIGITS)) begin
            value <= ACC_W'(value * 10 + ACC_W'(dig));
            ndig  <= ndig + 1'b1;
        end
    end

    assign empty    = (ndig == '0);
    assign overflow = dig_en && !clr && (ndig == ND_W'(MAX_DIGITS));

    a_r8_acc_bound: assert property (@(posedge clk) disable iff (!rst_n)
        value <= ACC_W'(ACC_MAX));

    a_r8_clamp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_en && !clr && ndig == ND_W'(MAX_DIGITS)) |=> $stable(value));

endmodule

// File: rtl/gsv_slot_table.sv
module gsv_slot_table #(
    parameter int DEPTH   = 32,
    parameter int SAT_W   = 8,
    parameter int CN0_W   = 7,
    parameter int CN0_MAX = 99,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_slot,
    input  logic [SAT_W-1:0] wr_sat,
    input  logic [CN0_W-1:0] wr_cn0,
    input  logic             wr_untr,
    input  logic [IDX_W-1:0] rd_slot,
    output logic [SAT_W-1:0] rd_sat,
    output logic [CN0_W-1:0] rd_cn0,
    output logic             rd_untr
);
    logic [SAT_W-1:0] sat_q  [DEPTH];
    logic [CN0_W-1:0] cn0_q  [DEPTH];
    logic             untr_q [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sat_q[s]  <= '0;
                cn0_q[s]  <= '0;
                untr_q[s] <= 1'b1;
            end else if (wr_en && wr_slot == IDX_W'(s)) begin
                sat_q[s]  <= wr_sat;
                cn0_q[s]  <= wr_cn0;
                untr_q[s] <= wr_untr;
            end
        end
    end

    assign rd_sat  = sat_q[rd_slot];
    assign rd_cn0  = cn0_q[rd_slot];
    assign rd_untr = untr_q[rd_slot];

    a_r4_cn0_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_cn0 <= CN0_W'(CN0_MAX)));

    a_r5_untracked_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_untr) |-> (wr_cn0 == '0));

    a_r10_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (sat_q[$past(wr_slot)] == $past(wr_sat)));

endmodule

// File: rtl/gsv_cn0_extractor.sv
module gsv_cn0_extractor
    import gsv_pkg::*;
#(
    parameter int TBL_DEPTH = 32,
    parameter int GROUPS    = 4,
    parameter int SAT_W     = 8,
    parameter int CN0_W     = 7,
    parameter int CN0_MAX   = 99,
    localparam int IDX_W    = $clog2(TBL_DEPTH),
    localparam int MAX_MSG  = TBL_DEPTH / GROUPS,
    localparam int FIDX_MAX = 3 + 4 * GROUPS + 1,
    localparam int FLD_W    = $clog2(FIDX_MAX + 1),
    localparam int SAT_MAX  = (1 << SAT_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic [IDX_W-1:0] rd_slot,
    output logic [SAT_W-1:0] rd_sat,
    output logic [CN0_W-1:0] rd_cn0,
    output logic             rd_untracked,
    output logic             upd_pulse,
    output logic             fmt_err,
    output logic             drop_pulse
);
    parse_state_t state, nxt;

    logic [2:0]       hdr_pos;
    logic [FLD_W-1:0] fidx;
    logic [ACC_W-1:0] total_r, msg_r;
    logic [SAT_W-1:0] sat_hold;

    logic is_dollar, is_sep, is_lf, is_digit;
    logic [ACC_W-1:0] acc_val;
    logic acc_empty, acc_ovf, acc_clr, dig_en;
    logic [FLD_W-1:0] rel, grp;
    logic [1:0] sub;
    logic in_grp, bad_msg, field_end;
    logic wr_en;
    logic [IDX_W-1:0] wr_slot;
    logic [SAT_W-1:0] sat_val;
    logic [CN0_W-1:0] cn0_val;

    assign is_dollar = (rx_byte == CH_DOLLAR);
    assign is_sep    = (rx_byte == CH_COMMA) || (rx_byte == CH_STAR) || (rx_byte == CH_CR);
    assign is_lf     = (rx_byte == CH_LF);
    assign is_digit  = (rx_byte >= 8'h30) && (rx_byte <= 8'h39);

    assign acc_clr   = rx_valid && (is_dollar || is_sep);
    assign dig_en    = rx_valid && is_digit && (state == PARSE_FIELDS);
    assign field_end = rx_valid && is_sep && (state == PARSE_FIELDS);

    gsv_field_acc #(.MAX_DIGITS(3)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (acc_clr),
        .dig_en   (dig_en),
        .dig      (rx_byte[3:0]),
        .value    (acc_val),
        .empty    (acc_empty),
        .overflow (acc_ovf)
    );

    assign rel     = fidx - FLD_W'(3);
    assign grp     = rel >> 2;
    assign sub     = rel[1:0];
    assign in_grp  = (fidx >= FLD_W'(3)) && (grp < FLD_W'(GROUPS));
    assign bad_msg = (acc_val == '0) || (acc_val > ACC_W'(MAX_MSG));

    assign sat_val = (acc_val > ACC_W'(SAT_MAX)) ? SAT_W'(SAT_MAX) : SAT_W'(acc_val);
    assign cn0_val = acc_empty ? '0 :
                     (acc_val > ACC_W'(CN0_MAX)) ? CN0_W'(CN0_MAX) : CN0_W'(acc_val);

    assign wr_en   = field_end && in_grp && (sub == 2'd3);
    assign wr_slot = IDX_W'((int'(msg_r) - 1) * GROUPS + int'(grp));

    gsv_slot_table #(
        .DEPTH   (TBL_DEPTH),
        .SAT_W   (SAT_W),
        .CN0_W   (CN0_W),
        .CN0_MAX (CN0_MAX)
    ) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_slot (wr_slot),
        .wr_sat  (sat_hold),
        .wr_cn0  (cn0_val),
        .wr_untr (acc_empty),
        .rd_slot (rd_slot),
        .rd_sat  (rd_sat),
        .rd_cn0  (rd_cn0),
        .rd_untr (rd_untracked)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        if (rx_valid) begin
            if (is_dollar) begin
                nxt = PARSE_HEADER;
            end else begin
                unique case (state)
                    PARSE_IDLE: nxt = PARSE_IDLE;
                    PARSE_HEADER: begin
                        if (hdr_pos < 3'(HDR_LEN))
                            nxt = (rx_byte == hdr_char(hdr_pos)) ? PARSE_HEADER : PARSE_SKIP;
                        else
                            nxt = is_sep ? PARSE_FIELDS : PARSE_SKIP;
                    end
                    PARSE_FIELDS: begin
                        if (is_lf)
                            nxt = PARSE_IDLE;
                        else if (is_sep && fidx == FLD_W'(1) && bad_msg)
                            nxt = PARSE_SKIP;
                    end
                    PARSE_SKIP: nxt = PARSE_SKIP;
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PARSE_IDLE;
        else        state <= nxt;
    end

    // datapath and registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_pos    <= '0;
            fidx       <= '0;
            total_r    <= '0;
            msg_r      <= '0;
            sat_hold   <= '0;
            upd_pulse  <= 1'b0;
            fmt_err    <= 1'b0;
            drop_pulse <= 1'b0;
        end else begin
            upd_pulse  <= rx_valid && is_lf && (state == PARSE_FIELDS) &&
                          (fidx >= FLD_W'(2)) && (msg_r == total_r);
            fmt_err    <= acc_ovf;
            drop_pulse <= field_end && (fidx == FLD_W'(1)) && bad_msg;
            if (rx_valid) begin
                if (is_dollar) begin
                    hdr_pos <= '0;
                end else if (state == PARSE_HEADER) begin
                    if (hdr_pos < 3'(HDR_LEN)) hdr_pos <= hdr_pos + 1'b1;
                    fidx <= '0;
                end else if (field_end) begin
                    if (fidx != FLD_W'(FIDX_MAX)) fidx <= fidx + 1'b1;
                    if (fidx == FLD_W'(0)) total_r <= acc_val;
                    if (fidx == FLD_W'(1)) msg_r   <= acc_val;
                    if (in_grp && sub == 2'd0) sat_hold <= sat_val;
                end
            end
        end
    end

    a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse |=> !upd_pulse);

    a_r9_pulse_after_lf: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse |-> $past(rx_valid && rx_byte == CH_LF));

    a_r7_dollar_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_byte == CH_DOLLAR) |=> (state == PARSE_HEADER && hdr_pos == '0));

    a_r6_drop_skips: assert property (@(posedge clk) disable iff (!rst_n)
        drop_pulse |-> (state == PARSE_SKIP));

    a_r2_no_write_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PARSE_FIELDS) |=> !upd_pulse);

endmodule

// File: tb/gsv_cn0_extractor_tb.sv
`timescale 1ns/1ps
module gsv_cn0_extractor_tb;

    typedef struct packed {
        logic [4:0] slot;
        logic [7:0] sat;
        logic [6:0] cn0;
        logic       untr;
    } exp_t;

    // expected table after the two-message group (R4, R5, R3)
    localparam exp_t VEC [7] = '{
        '{5'd0, 8'd1,  7'd46, 1'b0},
        '{5'd1, 8'd2,  7'd0,  1'b1},
        '{5'd2, 8'd12, 7'd39, 1'b0},
        '{5'd3, 8'd14, 7'd45, 1'b0},
        '{5'd4, 8'd15, 7'd99, 1'b0},
        '{5'd5, 8'd17, 7'd33, 1'b0},
        '{5'd6, 8'd0,  7'd0,  1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic [4:0] rd_slot = '0;
    logic [7:0] rd_sat;
    logic [6:0] rd_cn0;
    logic       rd_untracked, upd_pulse, fmt_err, drop_pulse;

    int checks = 0, errors = 0;
    int n_upd = 0, n_fmt = 0, n_drop = 0;
    bit done = 0;

    always #2 clk = ~clk;

    gsv_cn0_extractor u_dut (
        .clk (clk), .rst_n (rst_n), .rx_valid (rx_valid), .rx_byte (rx_byte),
        .rd_slot (rd_slot), .rd_sat (rd_sat), .rd_cn0 (rd_cn0),
        .rd_untracked (rd_untracked), .upd_pulse (upd_pulse),
        .fmt_err (fmt_err), .drop_pulse (drop_pulse)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            n_upd  += int'(upd_pulse);
            n_fmt  += int'(fmt_err);
            n_drop += int'(drop_pulse);
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_slot(input string req, input int slot, input int sat,
                            input int cn0, input int untr);
        rd_slot = 5'(slot);
        #0.5;
        chk({req, " sat"},  int'(rd_sat), sat);
        chk({req, " cn0"},  int'(rd_cn0), cn0);
        chk({req, " untr"}, int'(rd_untracked), untr);
    endtask

    task automatic send_str(input string s);
        for (int i = 0; i < s.len(); i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_byte  = s[i];
        end
        @(negedge clk);
        rx_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int exp_upd;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 upd", int'(upd_pulse), 0);
        chk("R1 fmt", int'(fmt_err), 0);
        chk("R1 drop", int'(drop_pulse), 0);
        for (int s = 0; s < 32; s += 7) chk_slot("R1 slot", s, 0, 0, 1);

        // R4 R5 R3: message 1 of 2, then 2 of 2
        send_str("$GPGSV,2,1,08,01,40,083,46,02,17,308,,12,07,344,39,14,22,228,45*75\r\n");
        chk("R9 no pulse when msg<total", n_upd, 0);
        send_str("$GPGSV,2,2,08,15,30,050,120,17,10,100,33*4A\r\n");
        chk("R9 pulse on last msg", n_upd, 1);
        for (int v = 0; v < 7; v++)
            chk_slot("R4 vec", int'(VEC[v].slot), int'(VEC[v].sat),
                     int'(VEC[v].cn0), int'(VEC[v].untr));
        exp_upd = 1;

        // R3 carriage return ends last signal field
        send_str("$GPGSV,1,1,01,07,5,6,38\r\n");
        exp_upd++;
        chk("R3 upd", n_upd, exp_upd);
        chk_slot("R3 cr sep", 0, 7, 38, 0);

        // R2 other sentences ignored
        send_str("$GPGSA,A,3,04,05,,,,,,,,,,,1.8,1.0,1.5*33\r\n");
        send_str("$GLGSV,1,1,01,65,10,20,44\r\n");
        chk("R2 upd", n_upd, exp_upd);
        chk_slot("R2 slot0 kept", 0, 7, 38, 0);

        // R6 out-of-range message numbers
        send_str("$GPGSV,9,9,01,50,1,1,40\r\n");
        send_str("$GPGSV,1,0,01,51,1,1,41\r\n");
        chk("R6 drops", n_drop, 2);
        chk("R6 upd", n_upd, exp_upd);
        chk_slot("R6 slot0 kept", 0, 7, 38, 0);

        // R10 live write before sentence end
        send_str("$GPGSV,1,1,01,21,1,1,44,");
        chk_slot("R10 live", 0, 21, 44, 0);
        chk("R10 no pulse yet", n_upd, exp_upd);
        send_str("\r\n");
        exp_upd++;
        chk("R10 upd", n_upd, exp_upd);

        // R7 mid-sentence restart
        send_str("$GPGSV,1,1,01,2$GPGSV,1,1,01,33,1,1,21\r\n");
        exp_upd++;
        chk("R7 upd", n_upd, exp_upd);
        chk_slot("R7 restart", 0, 33, 21, 0);

        // R8 over-long field
        send_str("$GPGSV,1,1,01,1234,1,1,55\r\n");
        exp_upd++;
        chk("R8 fmt", n_fmt, 1);
        chk_slot("R8 clamp", 0, 123, 55, 0);

        // R9 / R4 third message of three
        send_str("$GPGSV,3,3,09,40,1,1,30\r\n");
        exp_upd++;
        chk("R9 upd 3of3", n_upd, exp_upd);
        chk_slot("R4 slot8", 8, 40, 30, 0);

        // R4 R5 top slots
        send_str("$GPGSV,8,8,32,90,1,1,,91,1,1,,92,1,1,,93,1,1,77\r\n");
        exp_upd++;
        chk_slot("R5 slot28", 28, 90, 0, 1);
        chk_slot("R4 slot31", 31, 93, 77, 0);
        chk("R9 upd final", n_upd, exp_upd);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule